// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block arbitrates interrupt sources for one processor that fetches its handler vector by reading a register (software vectoring). Sources are a set of peripheral request lines and a few flag bits that software sets and clears itself. Each source owns a 4-bit priority level. In every cycle the block finds the best pending source. If that source's level is strictly above the current priority level, it raises a single request line to the processor.

The handler reads the acknowledge register to learn which source won. That read saves the current priority level on an internal hardware stack and raises the current level to the winner's level, so equal or lower sources are masked. At the end of the handler, software clears the source and writes the end-of-interrupt register. The write pops the stack and restores the level that was interrupted. The block does not look again for the source whose handler was preempted; the request line only follows the normal comparison against the restored level. All configuration and handshake accesses use a simple single-cycle register bus.

Top module: `intc_top`

## Requirements
- R1: `irq_o` is registered. One cycle after some pending source has a nonzero level strictly greater than the current level (address 0, bits [3:0]), `irq_o` reads 1. A source whose level is equal to or below the current level keeps it at 0. A source's level is set at address 8+vector, bits [3:0].
- R2: A source whose level is 0 never raises `irq_o`, whatever the current level is.
- R3: Software flag bit j is vector j. Peripheral line k is vector NUM_SW+k. When several pending sources share the highest level, the lowest vector number wins.
- R4: The acknowledge register (address 1, bits [4:0]) takes the winning vector in the same edge that makes `irq_o` go from 0 to 1. It keeps that value until the next 0-to-1 change of `irq_o`, even if the pending sources change while `irq_o` stays high.
- R5: A read of the acknowledge register pushes the current level onto the stack and sets the current level to the level of the acknowledged source. `irq_o` is 0 in the following cycle unless a strictly higher source is pending.
- R6: A write of any data to the end-of-interrupt register (address 2) pops the stack into the current level. A source still pending at exactly the restored level does not raise `irq_o`.
- R7: Nested acknowledges are undone in reverse order: successive end-of-interrupt writes restore the saved levels last-saved first.
- R8: A write to address 4 sets the software flags where the data bits are 1. A write to address 5 clears them where the data bits are 1. A read of address 4 returns the flags. A cleared flag no longer requests.
- R9: The stack holds 15 levels. A push onto a full stack discards the saved level, still raises the current level, and sets sticky status bit 0 (address 3). A pop from an empty stack leaves the current level unchanged and sets sticky status bit 1. Writing 1 to a status bit clears it.
- R10: After reset, `irq_o`, the current level, the acknowledge vector, the status bits, the software flags and every source level are all 0.
- R11: A write to address 0 sets the current level directly, and a read of address 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req_i | input | NUM_PERIPH | Peripheral request lines, active high |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register, same cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A table of request patterns is applied against several current levels. The patterns cover:
- a single source just above, equal to and just below the current level, which separates strict from non-strict comparison;
- sources at level 0, which must stay silent;
- mixed peripheral and software sources sharing the top level, which fixes the tie order by vector number;
- dense patterns where only one source clears the threshold.

Directed sequences follow. A higher source is raised while the line is already high, which shows the vector is captured on the rising change only. Two nested acknowledges are unwound, which shows stack order and that a still-pending source at the restored level stays masked. Sixteen pushes and sixteen pops show the sticky overflow and underflow behaviour.

// File: rtl/intc_pkg.sv
// Package intc_pkg
// Shared widths, register addresses and the priority type of the
// interrupt controller. Assumes a word-addressed register bus.
package intc_pkg;
    localparam int PRIO_W    = 4;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 16;
    localparam int PRIO_BASE = 8;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam logic [ADDR_W-1:0] A_CURPRI = 6'd0;
    localparam logic [ADDR_W-1:0] A_ACK    = 6'd1;
    localparam logic [ADDR_W-1:0] A_EOI    = 6'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'd3;
    localparam logic [ADDR_W-1:0] A_SWSET  = 6'd4;
    localparam logic [ADDR_W-1:0] A_SWCLR  = 6'd5;
endpackage

// File: rtl/intc_cfg.sv
// Module intc_cfg
// Holds one priority level per source and the software request flags.
// Assumes one bus write per cycle; the write strobe is already qualified.
module intc_cfg
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int NUM_SW  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [NUM_SW-1:0]              sw_o
);
    localparam int USED_W = (PRIO_W > NUM_SW) ? PRIO_W : NUM_SW;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:USED_W];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_level
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PRIO_BASE + gi);
            prio_t level_q;

            // Per-source level register, written at its own address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    level_q <= '0;
                else if (wr_en && addr == MY_ADDR)
                    level_q <= wdata[PRIO_W-1:0];
            end

            assign prio_o[gi] = level_q;
        end
    endgenerate

    // Software flags: set-by-one and clear-by-one addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_o <= '0;
        else if (wr_en && addr == A_SWSET)
            sw_o <= sw_o | wdata[NUM_SW-1:0];
        else if (wr_en && addr == A_SWCLR)
            sw_o <= sw_o & ~wdata[NUM_SW-1:0];
    end
endmodule

// File: rtl/intc_arbiter.sv
// Module intc_arbiter
// Combinational search for the pending source with the highest nonzero
// level; on a tie the lowest source index wins. Level 0 never wins.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 20,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           valid_o,
    output prio_t                          prio_o,
    output logic [VEC_W-1:0]               vec_o
);
    logic [NUM_SRC-1:0][PRIO_W-1:0] eff;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_mask
            assign eff[gi] = req_i[gi] ? prio_i[gi] : '0;
        end
    endgenerate

    // Scan from the highest index down so an equal level at a lower index replaces it.
    always_comb begin
        prio_o = '0;
        vec_o  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eff[i] != '0 && eff[i] >= prio_o) begin
                prio_o = eff[i];
                vec_o  = VEC_W'(i);
            end
        end
        valid_o = (prio_o != '0);
    end
endmodule

// File: rtl/intc_lifo.sv
// Module intc_lifo
// Stack of saved priority levels. A push when full is dropped and flagged;
// a pop when empty is flagged. Assumes push and pop are not both active
// in one cycle; if they are, the push wins.
module intc_lifo #(
    parameter int DEPTH = 15,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         full,
    output logic         ovf_pulse,
    output logic         unf_pulse
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] top_idx;

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign top_idx   = count - 1'b1;
    assign top_data  = empty ? '0 : mem[top_idx];
    assign ovf_pulse = push && full;
    assign unf_pulse = pop && !push && empty;

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[count] <= push_data;
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push && !full)
            count <= count + 1'b1;
        else if (pop && !push && !empty)
            count <= count - 1'b1;
    end
endmodule

// File: rtl/intc_top.sv
// Module intc_top
// Preemptive priority interrupt controller, software vectoring.
// Compares the best pending source against the current level, drives a
// registered request line, captures the vector on its rising change, and
// saves or restores levels through a hardware stack on acknowledge reads and
// end-of-interrupt writes. Assumes at most one bus access per cycle.
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_PERIPH = 16,
    parameter int NUM_SW     = 4,
    parameter int LIFO_DEPTH = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  irq_o
);
    localparam int NUM_SRC = NUM_PERIPH + NUM_SW;
    localparam int VEC_W   = $clog2(NUM_SRC);

    logic                           wr_en, ack_rd, eoi_wr, pri_wr, stat_wr;
    logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
    logic [NUM_SW-1:0]              sw_flags;
    logic [NUM_SRC-1:0]             src_req;
    logic                           arb_valid;
    prio_t                          arb_prio;
    logic [VEC_W-1:0]               arb_vec;
    prio_t                          pri_q, pri_d, lifo_pop_data, ack_prio_q;
    logic [VEC_W-1:0]               ack_vec_q;
    logic                           irq_q, cand;
    logic                           lifo_empty, lifo_full, lifo_ovf, lifo_unf;
    logic                           ovf_q, unf_q;

    assign wr_en   = bus_sel_i && bus_wr_i;
    assign ack_rd  = bus_sel_i && !bus_wr_i && bus_addr_i == A_ACK;
    assign eoi_wr  = wr_en && bus_addr_i == A_EOI;
    assign pri_wr  = wr_en && bus_addr_i == A_CURPRI;
    assign stat_wr = wr_en && bus_addr_i == A_STAT;
    assign src_req = {periph_req_i, sw_flags};
    assign irq_o   = irq_q;

    intc_cfg #(.NUM_SRC(NUM_SRC), .NUM_SW(NUM_SW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (bus_addr_i),
        .wdata  (bus_wdata_i),
        .prio_o (src_prio),
        .sw_o   (sw_flags)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .req_i   (src_req),
        .prio_i  (src_prio),
        .valid_o (arb_valid),
        .prio_o  (arb_prio),
        .vec_o   (arb_vec)
    );

    intc_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W)) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_rd),
        .pop       (eoi_wr),
        .push_data (pri_q),
        .top_data  (lifo_pop_data),
        .empty     (lifo_empty),
        .full      (lifo_full),
        .ovf_pulse (lifo_ovf),
        .unf_pulse (lifo_unf)
    );

    // Next current level from a direct write, an acknowledge read or a pop.
    always_comb begin
        pri_d = pri_q;
        if (pri_wr)
            pri_d = bus_wdata_i[PRIO_W-1:0];
        else if (ack_rd)
            pri_d = ack_prio_q;
        else if (eoi_wr && !lifo_empty)
            pri_d = lifo_pop_data;
    end

    // Request condition measured against the level that takes effect next.
    assign cand = arb_valid && (arb_prio > pri_d);

    // Current level, request line, and vector capture on the rising change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q      <= '0;
            irq_q      <= 1'b0;
            ack_vec_q  <= '0;
            ack_prio_q <= '0;
        end else begin
            pri_q <= pri_d;
            irq_q <= cand;
            if (cand && !irq_q) begin
                ack_vec_q  <= arb_vec;
                ack_prio_q <= arb_prio;
            end
        end
    end

    // Sticky stack error flags, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= lifo_ovf || (ovf_q && !(stat_wr && bus_wdata_i[0]));
            unf_q <= lifo_unf || (unf_q && !(stat_wr && bus_wdata_i[1]));
        end
    end

    // Read data multiplexer for the addressed register.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CURPRI: bus_rdata_o[PRIO_W-1:0] = pri_q;
            A_ACK:    bus_rdata_o[VEC_W-1:0]  = ack_vec_q;
            A_STAT:   bus_rdata_o[1:0]        = {unf_q, ovf_q};
            A_SWSET:  bus_rdata_o[NUM_SW-1:0] = sw_flags;
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (bus_addr_i == ADDR_W'(PRIO_BASE + i))
                        bus_rdata_o[PRIO_W-1:0] = src_prio[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/intc_checks.sv
// Module intc_checks
// Protocol checks for intc_top, attached by bind. Observes the request
// line, current level, captured vector and the stack interface.
module intc_checks
    import intc_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input prio_t            pri_q,
    input prio_t            ack_prio_q,
    input logic [VEC_W-1:0] ack_vec_q,
    input logic             ack_rd,
    input logic             eoi_wr,
    input logic             lifo_empty,
    input logic             lifo_full,
    input prio_t            lifo_pop_data
);
    // R1: a rising request always carries a level above the current one.
    a_r1_rise_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (ack_prio_q > pri_q));

    // R2: a raised line never stands for a level-0 source.
    a_r2_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ack_prio_q != '0));

    // R4: the captured vector changes only together with a rising request.
    a_r4_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(irq_o) |-> $stable(ack_vec_q));

    // R5: an acknowledge read moves the current level to the acknowledged level.
    a_r5_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd |=> (pri_q == $past(ack_prio_q)));

    // R6: an end-of-interrupt write restores the top of the stack.
    a_r6_eoi_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !lifo_empty) |=> (pri_q == $past(lifo_pop_data)));

    // R9: a pop from an empty stack leaves the level alone.
    a_r9_underflow_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && lifo_empty) |=> $stable(pri_q));

    // R9: a push onto a full stack leaves it full.
    a_r9_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && lifo_full) |=> lifo_full);
endmodule

bind intc_top intc_checks #(.VEC_W(VEC_W)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_o         (irq_o),
    .pri_q         (pri_q),
    .ack_prio_q    (ack_prio_q),
    .ack_vec_q     (ack_vec_q),
    .ack_rd        (ack_rd),
    .eoi_wr        (eoi_wr),
    .lifo_empty    (lifo_empty),
    .lifo_full     (lifo_full),
    .lifo_pop_data (lifo_pop_data)
);

// File: tb/intc_top_bench.sv
// Bench for intc_top: table-driven arbitration rows, then directed tests.
module intc_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 16;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] periph_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int  n_chk = 0;
    int  n_bad = 0;
    logic done = 1'b0;

    intc_top u_intc_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .periph_req_i (periph_req),
        .bus_sel_i    (bus_sel),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_o        (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Row: sw flags[4], peripheral lines[16], current level[4], expected irq[1], expected vector[5].
    // Source level written by the bench: (vector * 5) % 16.
    localparam logic [29:0] TABLE [NROWS] = '{
        {4'h0, 16'h0001, 4'd0,  1'b1, 5'd4},
        {4'h0, 16'h0001, 4'd4,  1'b0, 5'd0},
        {4'h0, 16'h0001, 4'd3,  1'b1, 5'd4},
        {4'h0, 16'h1000, 4'd0,  1'b0, 5'd0},
        {4'h0, 16'h0006, 4'd0,  1'b1, 5'd6},
        {4'h0, 16'h8004, 4'd0,  1'b1, 5'd19},
        {4'h0, 16'h8004, 4'd15, 1'b0, 5'd0},
        {4'h8, 16'h8000, 4'd0,  1'b1, 5'd3},
        {4'h2, 16'h2001, 4'd0,  1'b1, 5'd1},
        {4'h4, 16'h4001, 4'd9,  1'b1, 5'd2},
        {4'h1, 16'h0000, 4'd0,  1'b0, 5'd0},
        {4'h0, 16'hFFFF, 4'd14, 1'b1, 5'd19},
        {4'h0, 16'h7FFF, 4'd14, 1'b0, 5'd0},
        {4'h0, 16'h0A00, 4'd10, 1'b1, 5'd15},
        {4'h0, 16'h0200, 4'd0,  1'b1, 5'd13},
        {4'h3, 16'h0040, 4'd1,  1'b1, 5'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [3:0]  t_sw, t_pri;
        logic [15:0] t_req;
        logic        t_irq;
        logic [4:0]  t_vec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        check("R10 irq", irq, 0);
        bus_read(6'd0, d);  check("R10 level", d, 0);
        bus_read(6'd3, d);  check("R10 status", d, 0);
        bus_read(6'd4, d);  check("R10 flags", d, 0);
        bus_read(6'd13, d); check("R10 source level", d, 0);
        bus_read(6'd1, d);  check("R10 ack vector", d, 0);
        bus_write(6'd2, 16'h0);                 // undo the push of that read
        bus_write(6'd3, 16'h3);

        // Program source levels: (v*5)%16
        for (int v = 0; v < 20; v++)
            bus_write(6'(8 + v), 16'((v * 5) % 16));
        bus_read(6'd14, d); check("R1 level readback", d, 16'd14);

        // Table rows: R1 R2 R3 R4 R5 R6 R11
        for (int r = 0; r < NROWS; r++) begin
            {t_sw, t_req, t_pri, t_irq, t_vec} = TABLE[r];
            periph_req = '0;
            bus_write(6'd5, 16'hF);
            bus_write(6'd0, {12'h0, t_pri});
            bus_read(6'd0, d); check("R11 level write", d, {12'h0, t_pri});
            bus_write(6'd4, {12'h0, t_sw});
            periph_req = t_req;
            settle();
            check($sformatf("R1 R2 R3 row %0d irq", r), irq, t_irq);
            if (t_irq) begin
                bus_read(6'd1, d);
                check($sformatf("R3 R4 row %0d vector", r), d, {11'h0, t_vec});
                check($sformatf("R5 row %0d irq drop", r), irq, 0);
                bus_write(6'd2, 16'h0);
                bus_read(6'd0, d);
                check($sformatf("R6 row %0d restore", r), d, {12'h0, t_pri});
            end
        end
        periph_req = '0;
        bus_write(6'd5, 16'hF);
        bus_write(6'd0, 16'h0);
        settle();

        // R4: a higher source while the line stays high does not recapture
        periph_req = 16'h0001;                  // vector 4, level 4
        settle();
        check("R4 first rise", irq, 1);
        periph_req = 16'h8001;                  // add vector 19, level 15
        settle();
        check("R4 line still high", irq, 1);
        bus_read(6'd1, d);
        check("R4 vector held", d, 16'd4);
        bus_read(6'd0, d);
        check("R5 level raised", d, 16'd4);
        bus_write(6'd2, 16'h0);
        periph_req = '0;
        settle();
        check("R4 line low after clear", irq, 0);

        // R7 nested preemption and R6 no re-raise at restored level
        periph_req = 16'h0001;                  // level 4
        settle();
        bus_read(6'd1, d); check("R7 outer vector", d, 16'd4);
        check("R5 outer drop", irq, 0);
        periph_req = 16'h0005;                  // add vector 6, level 14
        settle();
        check("R7 preempt raise", irq, 1);
        bus_read(6'd1, d); check("R7 inner vector", d, 16'd6);
        bus_read(6'd0, d); check("R7 inner level", d, 16'd14);
        periph_req = 16'h0001;                  // inner source cleared
        bus_write(6'd2, 16'h0);
        bus_read(6'd0, d); check("R7 first restore", d, 16'd4);
        settle();
        check("R6 preempted source masked", irq, 0);
        periph_req = '0;
        bus_write(6'd2, 16'h0);
        bus_read(6'd0, d); check("R7 second restore", d, 16'd0);
        settle();
        check("R6 idle after unwind", irq, 0);

        // R8 software flags
        bus_write(6'd4, 16'h5);
        bus_read(6'd4, d); check("R8 set", d, 16'h5);
        bus_write(6'd5, 16'h1);
        bus_read(6'd4, d); check("R8 clear", d, 16'h4);
        bus_write(6'd5, 16'hF);
        bus_write(6'd4, 16'h8);                 // vector 3, level 15
        settle();
        check("R8 flag requests", irq, 1);
        bus_write(6'd5, 16'h8);
        settle();
        check("R8 cleared flag negates", irq, 0);

        // R9 overflow and underflow
        bus_write(6'd0, 16'h2);
        for (int k = 0; k < 16; k++) begin
            bus_read(6'd1, d);
            if (k == 15) check("R4 vector kept", d, 16'd3);
        end
        bus_read(6'd0, d); check("R9 level after overflow", d, 16'd15);
        bus_read(6'd3, d); check("R9 overflow flag", d, 16'h1);
        for (int k = 0; k < 15; k++) bus_write(6'd2, 16'h0);
        bus_read(6'd0, d); check("R9 bottom restored", d, 16'd2);
        bus_write(6'd2, 16'h0);
        bus_read(6'd0, d); check("R9 underflow keeps level", d, 16'd2);
        bus_read(6'd3, d); check("R9 both flags", d, 16'h3);
        bus_write(6'd3, 16'h1);
        bus_read(6'd3, d); check("R9 clear overflow only", d, 16'h2);
        bus_write(6'd3, 16'h2);
        bus_read(6'd3, d); check("R9 clear underflow", d, 16'h0);
        check("R1 idle at end", irq, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule